// File: doc/BRIEF.md
# Data-Ready Acknowledge Aggregator

This block records which of several filter channels holds a fresh result that software has not yet collected. Each channel has one pending flag. The flag sets when the channel's filter reports a new data word. It clears when the channel's data register is read. A single data-ready pin is active while any flag is pending. A control bit selects the pin's polarity.

A channel's flag can set only when the channel is qualified. Qualification needs three things:
- The channel's acknowledge enable bit is high.
- At least one of its sinc filter or integrator is enabled.
- Its two oversampling ratios are not both programmed to 1.

The flag vector is presented as a status word. Software reads it to find which channel to service.

Top module: `dready_ack_agg`

## Requirements
- R1: While reset is active and after it is released with no strobes, every bit of `flags_o` is 0 and `rdy_o` equals `pol_inv_i`, which is its inactive level.
- R2: When `new_data_i[i]` is high on a clock edge and channel i is qualified, `flags_o[i]` reads 1 after that edge. Bit i of `flags_o` belongs to channel i.
- R3: When `rd_data_i[i]` is high and `new_data_i[i]` is low on a clock edge, `flags_o[i]` reads 0 after that edge.
- R4: When `new_data_i[i]` and `rd_data_i[i]` are both high on the same edge and channel i is qualified, `flags_o[i]` reads 1 after that edge.
- R5: When `ack_en_i[i]` is low, a new-data strobe on channel i leaves `flags_o[i]` unchanged.
- R6: When `sinc_en_i[i]` and `intg_en_i[i]` are both low, a new-data strobe on channel i leaves `flags_o[i]` unchanged.
- R7: The fields `sinc_osr_i[i*OSR_W +: OSR_W]` and `intg_osr_i[i*OSR_W +: OSR_W]` hold ratio values directly. When both fields of channel i equal 1, a new-data strobe on channel i leaves the flag unchanged. If only one of the two fields equals 1, the strobe still sets the flag.
- R8: With `pol_inv_i` = 0, `rdy_o` is 1 when any flag is set. With `pol_inv_i` = 1, `rdy_o` is 0 when any flag is set.
- R9: `rdy_o` returns to its inactive level only when every flag is clear. Clearing a subset of the pending flags keeps the pin active.
- R10: A pending flag stays set across edges without a read strobe for its channel, whatever the qualification inputs do. A read strobe on a channel whose flag is clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| new_data_i | input | N_CH | Per-channel new-result strobe |
| rd_data_i | input | N_CH | Per-channel data-register read strobe |
| ack_en_i | input | N_CH | Per-channel acknowledge enable |
| sinc_en_i | input | N_CH | Per-channel sinc filter enable |
| intg_en_i | input | N_CH | Per-channel integrator enable |
| sinc_osr_i | input | N_CH*OSR_W | Per-channel sinc oversampling ratio fields |
| intg_osr_i | input | N_CH*OSR_W | Per-channel integrator oversampling ratio fields |
| pol_inv_i | input | 1 | Pin polarity: 1 inverts the data-ready pin |
| flags_o | output | N_CH | Pending flag vector for status reads |
| rdy_o | output | 1 | Data-ready pin |

## Verification
The bench builds the block with N_CH = 4 and OSR_W = 2.

The narrow ratio field makes the value 1 common under random stimulus, for one field and for both fields of a channel. The unity-ratio block is therefore exercised often, alongside the enable gates. With four channels, random traffic often leaves several flags pending at once. This covers partial clears that must keep the pin active, and same-cycle set and read strobes on one channel.

// File: rtl/dready_ack_pkg.sv
package dready_ack_pkg;
  localparam int unsigned DEF_N_CH  = 4;
  localparam int unsigned DEF_OSR_W = 8;

  function automatic logic pin_level(input logic any_set, input logic inv);
    return any_set ^ inv;
  endfunction
endpackage

// File: rtl/dready_ack_gate.sv
module dready_ack_gate #(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned OSR_W = 8
) (
  input  logic [N_CH-1:0]       ack_en_i,
  input  logic [N_CH-1:0]       sinc_en_i,
  input  logic [N_CH-1:0]       intg_en_i,
  input  logic [N_CH*OSR_W-1:0] sinc_osr_i,
  input  logic [N_CH*OSR_W-1:0] intg_osr_i,
  output logic [N_CH-1:0]       qual_o
);
  localparam logic [OSR_W-1:0] UNITY = OSR_W'(1);

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic any_path;
    logic both_unity;
    assign any_path   = sinc_en_i[i] | intg_en_i[i];
    assign both_unity = (sinc_osr_i[i*OSR_W +: OSR_W] == UNITY) &&
                        (intg_osr_i[i*OSR_W +: OSR_W] == UNITY);
    assign qual_o[i]  = ack_en_i[i] & any_path & ~both_unity;
  end
endmodule

// File: rtl/dready_ack_flags.sv
module dready_ack_flags #(
  parameter int unsigned N_CH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] set_i,
  input  logic [N_CH-1:0] clr_i,
  output logic [N_CH-1:0] flags_o
);
  for (genvar i = 0; i < N_CH; i++) begin : g_flag
    logic q;
    // set wins over clear: the newer sample stays flagged
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;
      else if (clr_i[i]) q <= 1'b0;
    end
    assign flags_o[i] = q;
  end
endmodule

// File: rtl/dready_ack_pin.sv
module dready_ack_pin #(
  parameter int unsigned N_CH = 4
) (
  input  logic [N_CH-1:0] flags_i,
  input  logic            inv_i,
  output logic            pin_o
);
  import dready_ack_pkg::*;
  assign pin_o = pin_level(|flags_i, inv_i);
endmodule

// File: rtl/dready_ack_agg.sv
module dready_ack_agg
  import dready_ack_pkg::*;
#(
  parameter int unsigned N_CH  = DEF_N_CH,
  parameter int unsigned OSR_W = DEF_OSR_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_CH-1:0]       new_data_i,
  input  logic [N_CH-1:0]       rd_data_i,
  input  logic [N_CH-1:0]       ack_en_i,
  input  logic [N_CH-1:0]       sinc_en_i,
  input  logic [N_CH-1:0]       intg_en_i,
  input  logic [N_CH*OSR_W-1:0] sinc_osr_i,
  input  logic [N_CH*OSR_W-1:0] intg_osr_i,
  input  logic                  pol_inv_i,
  output logic [N_CH-1:0]       flags_o,
  output logic                  rdy_o
);
  logic [N_CH-1:0] qual;
  logic [N_CH-1:0] set_v;

  dready_ack_gate #(.N_CH(N_CH), .OSR_W(OSR_W)) u_gate (
    .ack_en_i  (ack_en_i),
    .sinc_en_i (sinc_en_i),
    .intg_en_i (intg_en_i),
    .sinc_osr_i(sinc_osr_i),
    .intg_osr_i(intg_osr_i),
    .qual_o    (qual)
  );

  assign set_v = new_data_i & qual;

  dready_ack_flags #(.N_CH(N_CH)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (rd_data_i),
    .flags_o(flags_o)
  );

  dready_ack_pin #(.N_CH(N_CH)) u_pin (
    .flags_i(flags_o),
    .inv_i  (pol_inv_i),
    .pin_o  (rdy_o)
  );
endmodule

// File: rtl/dready_ack_chk.sv
module dready_ack_chk #(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned OSR_W = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [N_CH-1:0]       new_data_i,
  input logic [N_CH-1:0]       rd_data_i,
  input logic [N_CH-1:0]       ack_en_i,
  input logic [N_CH-1:0]       sinc_en_i,
  input logic [N_CH-1:0]       intg_en_i,
  input logic [N_CH*OSR_W-1:0] sinc_osr_i,
  input logic [N_CH*OSR_W-1:0] intg_osr_i,
  input logic                  pol_inv_i,
  input logic [N_CH-1:0]       flags_o,
  input logic                  rdy_o
);
  logic [N_CH-1:0] ok_v;
  always_comb begin
    for (int i = 0; i < N_CH; i++)
      ok_v[i] = ack_en_i[i] && (sinc_en_i[i] || intg_en_i[i]) &&
                !((sinc_osr_i[i*OSR_W +: OSR_W] == OSR_W'(1)) &&
                  (intg_osr_i[i*OSR_W +: OSR_W] == OSR_W'(1)));
  end

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |=> (flags_o == '0) || rst_ni); // R1

  AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(new_data_i & ok_v) |=> ((flags_o & $past(new_data_i & ok_v)) == $past(new_data_i & ok_v))); // R2

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(rd_data_i & ~new_data_i) |=> ((flags_o & $past(rd_data_i & ~new_data_i)) == '0)); // R3

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(~flags_o & ~(new_data_i & ok_v)) |=>
      ((flags_o & $past(~flags_o & ~(new_data_i & ok_v))) == '0)); // R5

  AST_HOLD_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(flags_o & ~rd_data_i) |=> ((flags_o & $past(flags_o & ~rd_data_i)) == $past(flags_o & ~rd_data_i))); // R10

  AST_PIN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o == '0) |-> (rdy_o == pol_inv_i)); // R9

  AST_PIN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o != '0) |-> (rdy_o != pol_inv_i)); // R8
endmodule

bind dready_ack_agg dready_ack_chk #(.N_CH(N_CH), .OSR_W(OSR_W)) u_chk (.*);

// File: tb/tb_dready_ack_agg.sv
`timescale 1ns/1ps
module tb_dready_ack_agg;
  localparam int unsigned N_CH  = 4;
  localparam int unsigned OSR_W = 2;

  logic                  clk_i = 1'b0;
  logic                  rst_ni = 1'b0;
  logic [N_CH-1:0]       new_data_i = '0, rd_data_i = '0;
  logic [N_CH-1:0]       ack_en_i = '1, sinc_en_i = '1, intg_en_i = '1;
  logic [N_CH*OSR_W-1:0] sinc_osr_i = '0, intg_osr_i = '0;
  logic                  pol_inv_i = 1'b0;
  logic [N_CH-1:0]       flags_o;
  logic                  rdy_o;

  int checks = 0, fails = 0;
  logic [N_CH-1:0] exp_f = '0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  dready_ack_agg #(.N_CH(N_CH), .OSR_W(OSR_W)) dut (.*);

  function automatic logic [N_CH-1:0] qual_m();
    logic [N_CH-1:0] q;
    for (int i = 0; i < N_CH; i++)
      q[i] = ack_en_i[i] & (sinc_en_i[i] | intg_en_i[i]) &
             ~((sinc_osr_i[i*OSR_W +: OSR_W] == 1) && (intg_osr_i[i*OSR_W +: OSR_W] == 1));
    return q;
  endfunction

  function automatic logic [N_CH-1:0] next_m(logic [N_CH-1:0] f);
    logic [N_CH-1:0] s;
    s = new_data_i & qual_m();
    return s | (f & ~rd_data_i);
  endfunction

  function automatic logic pin_m(logic [N_CH-1:0] f);
    return (f != '0) ^ pol_inv_i;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // apply inputs at negedge, update model at posedge, sample at next negedge
  task automatic step(string req);
    @(posedge clk_i);
    exp_f = next_m(exp_f);
    @(negedge clk_i);
    chk(req, 32'(flags_o), 32'(exp_f));
    chk(req, 32'(rdy_o), 32'(pin_m(exp_f)));
    new_data_i = '0;
    rd_data_i  = '0;
  endtask

  task automatic cfg_default();
    ack_en_i = '1; sinc_en_i = '1; intg_en_i = '1;
    sinc_osr_i = '0; intg_osr_i = '0;
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed);
    #1;
    chk("R1", 32'(flags_o), 0);
    chk("R1", 32'(rdy_o), 0);
    pol_inv_i = 1'b1; #1;
    chk("R1", 32'(rdy_o), 1);
    pol_inv_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    step("R1");

    // R2 set, R8 pin active high
    new_data_i = 4'b0001; step("R2");
    chk("R8", 32'(rdy_o), 1);
    // R11-style mapping: channel 2 only
    new_data_i = 4'b0100; step("R2");
    chk("R2", 32'(flags_o), 32'h5);
    // R9 partial clear keeps pin
    rd_data_i = 4'b0001; step("R3");
    chk("R9", 32'(rdy_o), 1);
    // R10 read of clear channel
    rd_data_i = 4'b0010; step("R10");
    // R4 same-cycle new and read
    new_data_i = 4'b0100; rd_data_i = 4'b0100; step("R4");
    chk("R4", 32'(flags_o[2]), 1);
    // R8 inverted polarity
    pol_inv_i = 1'b1; #1;
    chk("R8", 32'(rdy_o), 0);
    rd_data_i = 4'b0100; step("R9");
    chk("R9", 32'(rdy_o), 1);
    pol_inv_i = 1'b0;
    // R5 ack enable low
    ack_en_i = 4'b1110; new_data_i = 4'b0001; step("R5");
    chk("R5", 32'(flags_o), 0);
    // R6 both paths disabled
    cfg_default(); sinc_en_i[1] = 0; intg_en_i[1] = 0; new_data_i = 4'b0010; step("R6");
    chk("R6", 32'(flags_o), 0);
    // only one path on still sets
    intg_en_i[1] = 1; new_data_i = 4'b0010; step("R6");
    // R7 both ratios 1
    cfg_default(); sinc_osr_i[3*OSR_W +: OSR_W] = 1; intg_osr_i[3*OSR_W +: OSR_W] = 1;
    new_data_i = 4'b1000; step("R7");
    chk("R7", 32'(flags_o[3]), 0);
    intg_osr_i[3*OSR_W +: OSR_W] = 2; new_data_i = 4'b1000; step("R7");
    chk("R7", 32'(flags_o[3]), 1);
    // R10 gating change holds pending flag
    ack_en_i = '0; sinc_en_i = '0; intg_en_i = '0; step("R10");
    chk("R10", 32'(flags_o), 32'ha);
    cfg_default();
    rd_data_i = 4'b1010; step("R3");
    chk("R9", 32'(rdy_o), 0);

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      new_data_i = N_CH'($urandom);
      rd_data_i  = N_CH'($urandom) & N_CH'($urandom);
      ack_en_i   = N_CH'($urandom) | N_CH'($urandom);
      sinc_en_i  = N_CH'($urandom);
      intg_en_i  = N_CH'($urandom);
      sinc_osr_i = (N_CH*OSR_W)'($urandom);
      intg_osr_i = (N_CH*OSR_W)'($urandom);
      if (n % 97 == 0) pol_inv_i = ~pol_inv_i;
      step("R2");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule